// File: doc/BRIEF.md
# Four-Phase Cross-Clock Command Link

This block carries one command, together with a data word, from a sender clock domain to a receiver clock domain. The two clocks are unrelated. Each side runs its own small state machine. The two machines talk through a single request line and a single acknowledge line, and the protocol is fully interlocked. The sender raises request and keeps it high until it sees acknowledge. The receiver acts exactly once on the request, raises acknowledge, and keeps it high until the request has dropped. The sender then waits for acknowledge to drop before it will take a new command.

Each control line enters the other domain through a flip-flop synchronizer chain clocked by the destination clock. The data word never passes through a synchronizer. The sender registers the word when it accepts a command and holds it unchanged for the whole handshake. The receiver samples that word only after the synchronized request has settled.

On the sender side, the producer offers a word with `snd_valid`. The block takes it on a clock edge where `snd_ready` is high. Back-pressure is simple: `snd_ready` is low for the entire handshake, and offers made during that time are not taken. On the receiver side there is no back-pressure. The consumer must take `rcv_data` in the single cycle where `rcv_valid` is high.

Top module: `cdc_cmd_link`

## Requirements
- R1: While either reset is asserted, and after both resets are released, `snd_busy` is 0, `snd_ready` is 1, `snd_done` is 0 and `rcv_valid` is 0.
- R2: A word is accepted on a rising `snd_clk` edge where `snd_valid` and `snd_ready` are both 1. From the next cycle, `snd_busy` is 1 and `snd_ready` is 0. `snd_ready` always equals the inverse of `snd_busy`.
- R3: While `snd_busy` is 1, `snd_valid` has no effect. No additional receiver strobe appears, and the word delivered is the one that was accepted.
- R4: Each accepted word produces exactly one `rcv_valid` pulse, one `rcv_clk` cycle wide. During that pulse, `rcv_data` equals the accepted word. Words arrive in the order they were accepted.
- R5: When the handshake completes, `snd_done` is high for exactly one `snd_clk` cycle. This happens in the same cycle that `snd_busy` returns to 0.
- R6: R2 to R5 hold when the receiver clock is faster than the sender clock, and also when it is slower.
- R7: Once raised, the request stays high until the synchronized acknowledge is seen. Once raised, the acknowledge stays high until the synchronized request is seen low.
- R8: The sender's held data word does not change while `snd_busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| snd_clk | input | 1 | Sender domain clock |
| snd_rst_n | input | 1 | Sender domain reset, active low, asynchronous |
| snd_valid | input | 1 | Command offer from the producer |
| snd_ready | output | 1 | Block can accept a command this cycle |
| snd_data | input | DATA_W | Word accompanying the command |
| snd_busy | output | 1 | Handshake in progress |
| snd_done | output | 1 | One-cycle pulse when the handshake completes |
| rcv_clk | input | 1 | Receiver domain clock |
| rcv_rst_n | input | 1 | Receiver domain reset, active low, asynchronous |
| rcv_valid | output | 1 | One-cycle strobe, one per accepted command |
| rcv_data | output | DATA_W | Word captured with the strobe |

## Verification
The assertions assume both resets are released while the link is idle. They also assume the producer's word is only consulted on the accepting edge, so no assertion constrains `snd_data` while busy. The bench releases both resets before it offers anything. It keeps `snd_valid` high with a deliberately wrong word throughout every handshake, which tests that offers made while busy are refused. The bench drops `snd_valid` in the same cycle it sees `snd_done`, so that no unintended second accept occurs.

// File: rtl/cdc_cmd_link_pkg.sv
package cdc_cmd_link_pkg;
  typedef enum logic [1:0] {
    SND_IDLE = 2'd0,
    SND_REQ  = 2'd1,
    SND_DROP = 2'd2
  } snd_state_t;

  typedef enum logic {
    RCV_IDLE = 1'b0,
    RCV_ACK  = 1'b1
  } rcv_state_t;
endpackage

// File: rtl/cdc_bit_sync.sv
module cdc_bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  localparam int N = (STAGES < 2) ? 2 : STAGES;

  logic [N-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[N-2:0], d};
  end

  assign q = chain[N-1];
endmodule

// File: rtl/cdc_cmd_sender.sv
module cdc_cmd_sender
  import cdc_cmd_link_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              busy,
  output logic              done,
  output logic              req,
  input  logic              ack_sync,
  output logic [DATA_W-1:0] hold_data
);
  snd_state_t        state;
  logic              req_q;
  logic              done_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= SND_IDLE;
      req_q  <= 1'b0;
      done_q <= 1'b0;
      data_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        SND_IDLE: if (in_valid) begin
          data_q <= in_data;
          req_q  <= 1'b1;
          state  <= SND_REQ;
        end
        SND_REQ: if (ack_sync) begin
          req_q <= 1'b0;
          state <= SND_DROP;
        end
        SND_DROP: if (!ack_sync) begin
          done_q <= 1'b1;
          state  <= SND_IDLE;
        end
        default: state <= SND_IDLE;
      endcase
    end
  end

  assign busy      = (state != SND_IDLE);
  assign in_ready  = !busy;
  assign done      = done_q;
  assign req       = req_q;
  assign hold_data = data_q;

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ack_sync) |=> req); // R7
  AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(hold_data)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5
  AST_BUSY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> busy); // R2
endmodule

// File: rtl/cdc_cmd_receiver.sv
module cdc_cmd_receiver
  import cdc_cmd_link_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_sync,
  input  logic [DATA_W-1:0] held_data,
  output logic              ack,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  rcv_state_t        state;
  logic              valid_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= RCV_IDLE;
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= 1'b0;
      unique case (state)
        RCV_IDLE: if (req_sync) begin
          data_q  <= held_data;
          valid_q <= 1'b1;
          state   <= RCV_ACK;
        end
        RCV_ACK: if (!req_sync) state <= RCV_IDLE;
        default: state <= RCV_IDLE;
      endcase
    end
  end

  assign ack       = (state == RCV_ACK);
  assign out_valid = valid_q;
  assign out_data  = data_q;

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R4
  AST_ACK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && req_sync) |=> ack); // R7
  AST_STROBE_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack) |-> out_valid); // R4
endmodule

// File: rtl/cdc_cmd_link.sv
module cdc_cmd_link #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              snd_clk,
  input  logic              snd_rst_n,
  input  logic              snd_valid,
  output logic              snd_ready,
  input  logic [DATA_W-1:0] snd_data,
  output logic              snd_busy,
  output logic              snd_done,
  input  logic              rcv_clk,
  input  logic              rcv_rst_n,
  output logic              rcv_valid,
  output logic [DATA_W-1:0] rcv_data
);
  logic              req_line;
  logic              ack_line;
  logic              req_in_rcv;
  logic              ack_in_snd;
  logic [DATA_W-1:0] held_word;

  cdc_cmd_sender #(.DATA_W(DATA_W)) u_sender (
    .clk       (snd_clk),
    .rst_n     (snd_rst_n),
    .in_valid  (snd_valid),
    .in_ready  (snd_ready),
    .in_data   (snd_data),
    .busy      (snd_busy),
    .done      (snd_done),
    .req       (req_line),
    .ack_sync  (ack_in_snd),
    .hold_data (held_word)
  );

  cdc_bit_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk   (rcv_clk),
    .rst_n (rcv_rst_n),
    .d     (req_line),
    .q     (req_in_rcv)
  );

  cdc_bit_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk   (snd_clk),
    .rst_n (snd_rst_n),
    .d     (ack_line),
    .q     (ack_in_snd)
  );

  cdc_cmd_receiver #(.DATA_W(DATA_W)) u_receiver (
    .clk       (rcv_clk),
    .rst_n     (rcv_rst_n),
    .req_sync  (req_in_rcv),
    .held_data (held_word),
    .ack       (ack_line),
    .out_valid (rcv_valid),
    .out_data  (rcv_data)
  );

  AST_READY_IDLE: assert property (@(posedge snd_clk) disable iff (!snd_rst_n)
    snd_done |-> (snd_ready && !snd_busy)); // R5
endmodule

// File: tb/cdc_cmd_link_bench.sv
`timescale 1ns/1ps
module cdc_cmd_link_bench;
  localparam int DATA_W = 8;

  logic              snd_clk = 1'b0;
  logic              rcv_clk = 1'b0;
  logic              snd_rst_n = 1'b0;
  logic              rcv_rst_n = 1'b0;
  logic              snd_valid = 1'b0;
  logic [DATA_W-1:0] snd_data = '0;
  logic              snd_ready, snd_busy, snd_done, rcv_valid;
  logic [DATA_W-1:0] rcv_data;

  real rcv_half = 1.5;
  int  checks = 0;
  int  errors = 0;
  int  rx_count = 0;
  int  rx_last = 0;
  int  cycles = 0;
  bit  finished = 1'b0;

  always #2.5 snd_clk = ~snd_clk;
  always #(rcv_half) rcv_clk = ~rcv_clk;

  cdc_cmd_link #(.DATA_W(DATA_W), .SYNC_STAGES(2)) u_cdc_cmd_link (
    .snd_clk   (snd_clk),
    .snd_rst_n (snd_rst_n),
    .snd_valid (snd_valid),
    .snd_ready (snd_ready),
    .snd_data  (snd_data),
    .snd_busy  (snd_busy),
    .snd_done  (snd_done),
    .rcv_clk   (rcv_clk),
    .rcv_rst_n (rcv_rst_n),
    .rcv_valid (rcv_valid),
    .rcv_data  (rcv_data)
  );

  always @(negedge rcv_clk) begin
    if (rcv_valid) begin
      rx_count = rx_count + 1;
      rx_last  = int'(rcv_data);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_word(input int word);
    int base;
    int waited;
    bit seen;
    waited = 0;
    @(negedge snd_clk);
    while (!snd_ready && waited < 200) begin
      @(negedge snd_clk);
      waited++;
    end
    base = rx_count;
    snd_valid = 1'b1;
    snd_data  = DATA_W'(word);
    @(negedge snd_clk);
    chk(snd_busy && !snd_ready, "R2 busy after accept", int'(snd_busy), 1);
    snd_data = DATA_W'(~word); // R3: offers while busy must be refused
    seen = 1'b0;
    waited = 0;
    while (!seen && waited < 400) begin
      @(negedge snd_clk);
      waited++;
      if (snd_done) begin
        seen = 1'b1;
        snd_valid = 1'b0;
      end
    end
    chk(seen, "R5 done pulse", int'(seen), 1);
    chk(!snd_busy, "R5 busy low with done", int'(snd_busy), 0);
    chk(rx_count == base + 1, "R4 R3 one strobe per accept", rx_count - base, 1);
    chk(rx_last == word, "R4 R3 delivered word", rx_last, word);
    @(negedge snd_clk);
    chk(!snd_done, "R5 done one cycle", int'(snd_done), 0);
    chk(rx_count == base + 1, "R3 no extra strobe", rx_count - base, 1);
  endtask

  always @(posedge snd_clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (4) @(negedge snd_clk);
    chk(!snd_busy && snd_ready && !snd_done, "R1 sender in reset", int'(snd_busy), 0);
    chk(!rcv_valid, "R1 receiver in reset", int'(rcv_valid), 0);
    snd_rst_n = 1'b1;
    rcv_rst_n = 1'b1;
    repeat (4) @(negedge snd_clk);
    chk(!snd_busy && snd_ready && !snd_done, "R1 sender after reset", int'(snd_busy), 0);
    chk(rx_count == 0, "R1 no strobe after reset", rx_count, 0);

    // R6: receiver clock faster than sender clock
    base = rx_count;
    for (int w = 0; w < 256; w++) send_word(w);
    chk(rx_count - base == 256, "R6 fast receiver total", rx_count - base, 256);

    // R6: receiver clock slower than sender clock
    rcv_half = 6.5;
    repeat (10) @(negedge snd_clk);
    base = rx_count;
    for (int w = 255; w >= 0; w--) send_word(w);
    chk(rx_count - base == 256, "R6 slow receiver total", rx_count - base, 256);

    // R6: nearly equal clocks
    rcv_half = 2.6;
    repeat (10) @(negedge snd_clk);
    base = rx_count;
    for (int w = 0; w < 64; w++) send_word((w * 37 + 11) % 256);
    chk(rx_count - base == 64, "R6 near-equal total", rx_count - base, 64);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule